// File: doc/BRIEF.md
# Timestamping Input Capture Channel

The channel watches one digital I/O line and records the moment of every rising edge on it. The moment is taken from a free-running local time base presented as two words: a seconds count and a count of clock cycles within the current second. Each record goes into an event FIFO. Software drains the FIFO through a small word-addressed read port. A level interrupt stays high while any record is waiting.

The line is the value seen at the pad, not the value the channel drives. Pulses that the same I/O generates on its output are therefore stamped exactly like edges that arrive from outside. The line is asynchronous, so it passes through a synchroniser before the edge detector. A time-valid input blocks stamping while the time base is not trustworthy. When the FIFO is full, further events are dropped and a sticky overflow flag records the loss.

The read port has three words. Address 0 returns the seconds word of the oldest record and leaves the FIFO unchanged. Address 1 returns the cycles word of the same record and removes that record. Address 2 is the status word. Reading the seconds word before the cycles word always yields a matched pair.

Top module: `ts_capture_chan`

## Requirements
- R1: After reset the FIFO is empty, the interrupt is low and the status word (address 2) reads 0. Status layout: bit 0 is "records waiting", bit 1 is overflow, bits 31:16 hold the fill count.
- R2: A rising edge on the line creates exactly one record. A line that stays high creates no further records, and a falling edge creates none.
- R3: The stamp is the seconds and cycles value presented at the third rising clock edge, counting the first edge that samples the line high as the first.
- R4: A line pulse that is high for a single clock period is recorded once.
- R5: While the time-valid input is low, edges create no record.
- R6: Records leave in arrival order. The FIFO holds 256 records.
- R7: An edge that arrives while the FIFO is full is dropped, the stored records are kept unchanged, and the overflow flag is set.
- R8: The overflow flag stays set until a write to address 2. A write to any other address leaves it set.
- R9: A read of address 0 returns the seconds word of the oldest record without removing it. A read of address 1 returns that record's cycles word (28 bits, upper bits zero) and removes it.
- R10: The interrupt output is high exactly while at least one record is waiting.
- R11: A read of address 1 or 0 on an empty FIFO returns 0 and leaves the FIFO empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Pad value of the watched I/O line (asynchronous) |
| time_valid_i | input | 1 | High while the time base is valid |
| sec_i | input | SEC_W | Current seconds count |
| cyc_i | input | CYC_W | Current cycle count within the second |
| rd_en_i | input | 1 | Read strobe for the addressed word |
| wr_en_i | input | 1 | Write strobe; a write to address 2 clears overflow |
| addr_i | input | 2 | Word address: 0 seconds, 1 cycles, 2 status |
| rdata_o | output | 32 | Read data for the addressed word |
| irq_o | output | 1 | Level interrupt while records are waiting |

## Verification
The line is driven with a long high level, a one-cycle pulse, a burst of closely spaced pulses and pulses while time is invalid. The long level separates edge detection from level detection. The one-cycle pulse shows that no narrow event is lost. The invalid-time pulses show that the gate is effective. A cycle counter that moves on every clock feeds the time input, so an off-by-one in the synchroniser depth shows up directly in the stamped value. The burst fills the FIFO past its depth, which exercises drop-on-full, ordering across pointer wrap and the clearing of the sticky flag.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;

  localparam logic [1:0] ADDR_SEC  = 2'd0;
  localparam logic [1:0] ADDR_CYC  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  // status word: fill count in the upper half, flags in the low bits
  function automatic logic [31:0] status_word(input logic waiting,
                                              input logic ovf,
                                              input logic [15:0] fill);
    return {fill, 14'd0, ovf, waiting};
  endfunction

  // fill count update for one clock
  function automatic logic [15:0] fill_next(input logic [15:0] cur,
                                            input logic inc,
                                            input logic dec);
    logic [15:0] r;
    r = cur;
    if (inc && !dec) r = cur + 16'd1;
    else if (dec && !inc) r = cur - 16'd1;
    return r;
  endfunction

endpackage

// File: rtl/ts_edge_sync.sv
module ts_edge_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic rise_o
);

  logic [SYNC_N-1:0] stage_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_N; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= 1'b0;
        else if (g == 0) stage_q[g] <= line_i;
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else prev_q <= stage_q[SYNC_N-1];
  end

  assign rise_o = stage_q[SYNC_N-1] & ~prev_q;

  // R2: a detected edge lasts one cycle only
  a_r2_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/ts_event_fifo.sv
module ts_event_fifo #(
  parameter int W     = 60,
  parameter int DEPTH = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  logic [W-1:0]               data_i,
  input  logic                       pop_i,
  output logic [W-1:0]               data_o,
  output logic [$clog2(DEPTH):0]     fill_o,
  output logic                       empty_o,
  output logic                       drop_o
);
  import ts_cap_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] fill_q;
  logic          full_w, push_ok, pop_ok;
  logic [15:0]   fill_upd;

  assign full_w  = (fill_q == CW'(DEPTH));
  assign empty_o = (fill_q == '0);
  assign push_ok = push_i & ~full_w;
  assign pop_ok  = pop_i & ~empty_o;
  assign drop_o  = push_i & full_w;
  assign fill_upd = fill_next(16'(fill_q), push_ok, pop_ok);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
      fill_q <= fill_upd[CW-1:0];
    end
  end

  assign data_o = mem[rd_ptr_q];
  assign fill_o = fill_q;

  // R6: never more records than the depth
  a_r6_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CW'(DEPTH));
  // R7: a dropped push leaves the stored count untouched
  a_r7_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_w && !pop_i) |=> $stable(fill_q));
  // R11: popping an empty FIFO keeps it empty
  a_r11_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i) |=> (fill_q == '0));

endmodule

// File: rtl/ts_cap_regs.sv
module ts_cap_regs #(
  parameter int SEC_W = 32,
  parameter int CYC_W = 28,
  parameter int CW    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en_i,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [SEC_W-1:0] head_sec_i,
  input  logic [CYC_W-1:0] head_cyc_i,
  input  logic [CW-1:0]    fill_i,
  input  logic             empty_i,
  input  logic             drop_i,
  output logic [31:0]      rdata_o,
  output logic             pop_o,
  output logic             ovf_o
);
  import ts_cap_pkg::*;

  logic ovf_q;
  logic clear_w;

  assign clear_w = wr_en_i & (addr_i == ADDR_STAT);
  assign pop_o   = rd_en_i & (addr_i == ADDR_CYC) & ~empty_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else if (drop_i) ovf_q <= 1'b1;
    else if (clear_w) ovf_q <= 1'b0;
  end

  always_comb begin
    case (addr_i)
      ADDR_SEC:  rdata_o = empty_i ? 32'd0 : 32'(head_sec_i);
      ADDR_CYC:  rdata_o = empty_i ? 32'd0 : 32'(head_cyc_i);
      ADDR_STAT: rdata_o = status_word(~empty_i, ovf_q, 16'(fill_i));
      default:   rdata_o = 32'd0;
    endcase
  end

  assign ovf_o = ovf_q;

  // R7: the flag only rises after a dropped event
  a_r7_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(drop_i));
  // R8: the flag only falls after a status write
  a_r8_ovf_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_q) |-> $past(wr_en_i && addr_i == ADDR_STAT));

endmodule

// File: rtl/ts_capture_chan.sv
module ts_capture_chan #(
  parameter int SEC_W  = 32,
  parameter int CYC_W  = 28,
  parameter int DEPTH  = 256,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic             time_valid_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic [CYC_W-1:0] cyc_i,
  input  logic             rd_en_i,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  output logic [31:0]      rdata_o,
  output logic             irq_o
);
  import ts_cap_pkg::*;

  localparam int EW = SEC_W + CYC_W;
  localparam int CW = $clog2(DEPTH) + 1;

  logic          rise_w, push_w, pop_w, empty_w, drop_w, ovf_w;
  logic [EW-1:0] head_w;
  logic [CW-1:0] fill_w;

  ts_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .rise_o(rise_w));

  assign push_w = rise_w & time_valid_i;

  ts_event_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_i(push_w), .data_i({sec_i, cyc_i}),
    .pop_i(pop_w), .data_o(head_w),
    .fill_o(fill_w), .empty_o(empty_w), .drop_o(drop_w));

  ts_cap_regs #(.SEC_W(SEC_W), .CYC_W(CYC_W), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .head_sec_i(head_w[EW-1:CYC_W]), .head_cyc_i(head_w[CYC_W-1:0]),
    .fill_i(fill_w), .empty_i(empty_w), .drop_i(drop_w),
    .rdata_o(rdata_o), .pop_o(pop_w), .ovf_o(ovf_w));

  assign irq_o = ~empty_w;

  // R10: interrupt only rises after a record was written
  a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(push_w));
  // R5: with time invalid the fill count cannot grow
  a_r5_no_stamp: assert property (@(posedge clk) disable iff (!rst_n)
    (!time_valid_i && !pop_w) |=> (fill_w <= $past(fill_w)));
  // R9: a seconds read does not remove a record
  a_r9_peek: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == ADDR_SEC && !push_w) |=> $stable(fill_w));
  // R8: a write elsewhere does not clear overflow
  a_r8_other_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i != ADDR_STAT && ovf_w) |=> ovf_w);

endmodule

// File: tb/ts_capture_chan_tb_top.sv
`timescale 1ns/1ps
module ts_capture_chan_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line = 1'b0;
  logic        tvalid = 1'b1;
  logic [31:0] sec = 32'd0;
  logic [27:0] tc;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] rdata;
  logic        irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [27:0] exp_cyc [0:256];

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tc <= 28'd0; else tc <= tc + 28'd1;

  ts_capture_chan dut_i (
    .clk(clk), .rst_n(rst_n), .line_i(line), .time_valid_i(tvalid),
    .sec_i(sec), .cyc_i(tc), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .addr_i(addr), .rdata_o(rdata), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // read a word; pop happens at the edge inside when addr is 1
  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a);
    @(negedge clk); addr = a; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // pulse the line; returns expected cycle stamp
  task automatic pulse(input int hi, output logic [27:0] stamp);
    @(negedge clk); line = 1'b1; stamp = tc + 28'd2;
    repeat (hi) @(negedge clk);
    line = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(2'd2, d); chk("R1 status", d, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_long_level;
    logic [27:0] s; logic [31:0] d;
    sec = 32'h1234_5678;
    pulse(12, s);
    rd(2'd2, d); chk("R2 one record for long level", d, {16'd1, 16'd1});
    chk("R10 irq high", {31'd0, irq}, 32'd1);
    rd(2'd0, d); chk("R9 seconds peek", d, 32'h1234_5678);
    rd(2'd0, d); chk("R9 second peek same", d, 32'h1234_5678);
    rd(2'd2, d); chk("R9 peek keeps fill", d, {16'd1, 16'd1});
    rd(2'd1, d); chk("R3 cycle stamp", d, {4'd0, s});
    rd(2'd2, d); chk("R9 cycles read pops", d, 32'd0);
    chk("R10 irq low when drained", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_short;
    logic [27:0] s; logic [31:0] d;
    sec = 32'h0000_00A5;
    pulse(1, s);
    rd(2'd2, d); chk("R4 one-cycle pulse recorded", d, {16'd1, 16'd1});
    rd(2'd0, d); chk("R4 seconds", d, 32'h0000_00A5);
    rd(2'd1, d); chk("R4 cycles", d, {4'd0, s});
  endtask

  task automatic t_invalid;
    logic [27:0] s; logic [31:0] d;
    tvalid = 1'b0;
    pulse(2, s);
    pulse(1, s);
    rd(2'd2, d); chk("R5 no record while invalid", d, 32'd0);
    chk("R5 irq stays low", {31'd0, irq}, 32'd0);
    tvalid = 1'b1;
  endtask

  task automatic t_empty_pop;
    logic [31:0] d;
    rd(2'd1, d); chk("R11 cycles on empty", d, 32'd0);
    rd(2'd0, d); chk("R11 seconds on empty", d, 32'd0);
    rd(2'd2, d); chk("R11 still empty", d, 32'd0);
  endtask

  task automatic t_order;
    logic [27:0] s [3]; logic [31:0] d;
    for (int i = 0; i < 3; i++) begin
      sec = 32'h100 + i;
      pulse(1, s[i]);
    end
    for (int i = 0; i < 3; i++) begin
      rd(2'd0, d); chk("R6 order seconds", d, 32'h100 + i);
      rd(2'd1, d); chk("R6 order cycles", d, {4'd0, s[i]});
    end
  endtask

  task automatic t_overflow;
    logic [31:0] d;
    sec = 32'hBEEF;
    for (int i = 0; i < 257; i++) pulse(1, exp_cyc[i]);
    rd(2'd2, d); chk("R7 full with overflow", d, {16'd256, 16'd3});
    wr(2'd0);
    rd(2'd2, d); chk("R8 other write keeps flag", d, {16'd256, 16'd3});
    wr(2'd2);
    rd(2'd2, d); chk("R8 status write clears flag", d, {16'd256, 16'd1});
    for (int i = 0; i < 256; i++) begin
      rd(2'd1, d); chk("R7 kept records in order", d, {4'd0, exp_cyc[i]});
    end
    rd(2'd2, d); chk("R6 drained after 256", d, 32'd0);
    chk("R10 irq low after drain", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_long_level();
    t_short();
    t_invalid();
    t_empty_pop();
    t_order();
    t_overflow();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule